// File: doc/BRIEF.md
# Over-Current Trip Threshold Calibrator

This block finds the over-current trip level of a switching regulator once, at power-up, by a counting search. A 6-bit counter drives an external reference DAC starting from zero. An external comparator reports when the DAC output has passed a voltage that a resistor sets. The counter then stops, and the code it holds becomes the stored trip setting. Each counter value is held for a programmable number of clocks before the comparator is looked at, so that the DAC has time to settle.

After a search, the block presents the effective trip code used by the high-side current comparator. Stored codes at or below a low-code limit give an effective code of zero. While soft-start is active, the effective code is doubled on a bus one bit wider than the stored code, so that the large inrush current does not trip the comparator. If the counter reaches its top value without the comparator ever reporting a crossing, the block flags "no limit" and disables trips altogether.

Top module: `ilim_cal_top`

## Requirements
- R1: After reset, dac_code is 0, and cal_busy, cal_done, no_limit, trip_enable and trip_code are all 0.
- R2: One cycle after a start is accepted, dac_code is 0. It then rises by exactly one every SETTLE_CLKS clocks (default 4) and is stable between steps.
- R3: The comparator is only examined on the last clock of each step. The search stops at the first code where cmp_above is 1, and dac_code then holds that code. Changes on cmp_above while idle have no effect on dac_code.
- R4: cal_done is a single-cycle pulse. If the start is sampled on clock edge 0 and the search ends at code c, cal_done is high from edge (c+1)*SETTLE_CLKS until the next edge.
- R5: If cmp_above is still 0 at the end of code 63, no_limit is set, dac_code stays at 63, trip_enable is 0 and trip_code is 0. A new start clears no_limit.
- R6: With a valid calibration, a stored code of 10 or less (LOW_CODE_MAX) gives trip_code 0, both with and without soft-start. A stored code of 11 or more passes through unchanged when soft-start is off.
- R7: While softstart_active is 1, trip_code is twice the effective stored code on a 7-bit bus, with no saturation (stored 63 gives 126). When softstart_active returns to 0, trip_code returns to the stored value in the same cycle.
- R8: cal_start is ignored while a search is in progress. The search result and its timing are unchanged.
- R9: trip_enable is 1 only after a search that ended on a crossing, and it is 0 while a search runs. trip_code is 0 whenever trip_enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_start | input | 1 | Launches a search when idle |
| cmp_above | input | 1 | Comparator: DAC output has passed the resistor-set voltage |
| softstart_active | input | 1 | High during soft-start; doubles the effective code |
| dac_code | output | 6 | Code driven to the reference DAC; holds the stored code after a search |
| cal_busy | output | 1 | Search in progress |
| cal_done | output | 1 | One-cycle pulse at the end of a search |
| no_limit | output | 1 | Search reached the top code with no crossing |
| trip_enable | output | 1 | Current-limit comparison is enabled |
| trip_code | output | 7 | Effective trip code to the current comparator |

## Verification
The hardest case to reach is a search that runs off the top of the counter. The comparator is never allowed to report a crossing, so the search must walk through all 64 codes. The bench's comparator model compares dac_code against a threshold, and setting that threshold above 63 forces this path. Setting the threshold to 63 exercises the neighbouring case, a crossing found on the very last code. A second start pulse issued in the middle of a search checks that starts are ignored while busy: the scoreboard's expected latency only holds if the second pulse has no effect.

// File: rtl/ilim_cal_pkg.sv
package ilim_cal_pkg;
    typedef enum logic [0:0] {
        CAL_IDLE   = 1'b0,
        CAL_SEARCH = 1'b1
    } cal_state_e;
endpackage

// File: rtl/ilim_step_timer.sv
module ilim_step_timer #(
    parameter int unsigned SETTLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_tick
);
    localparam int unsigned TW = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(SETTLE_CLKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_s;

    tmr_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run)                r_d.cnt = '0;
        else if (r_q.cnt == LAST) r_d.cnt = '0;
        else                     r_d.cnt = r_q.cnt + 1'b1;
    end

    assign step_tick = run && (r_q.cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    generate
        if (SETTLE_CLKS > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step_tick |=> !step_tick);
        end
    endgenerate
endmodule

// File: rtl/ilim_search_fsm.sv
module ilim_search_fsm
    import ilim_cal_pkg::*;
#(
    parameter int unsigned CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              cmp_above,
    input  logic              step_tick,
    output logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              done,
    output logic              no_limit,
    output logic              cal_ok
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        cal_state_e        state;
        logic [CODE_W-1:0] code;
        logic              done;
        logic              no_limit;
        logic              ok;
    } fsm_s;

    fsm_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            CAL_IDLE: begin
                if (cal_start) begin
                    r_d.state    = CAL_SEARCH;
                    r_d.code     = '0;
                    r_d.no_limit = 1'b0;
                    r_d.ok       = 1'b0;
                end
            end
            CAL_SEARCH: begin
                if (step_tick) begin
                    if (cmp_above) begin
                        r_d.state = CAL_IDLE;
                        r_d.done  = 1'b1;
                        r_d.ok    = 1'b1;
                    end else if (r_q.code == CODE_MAX) begin
                        r_d.state    = CAL_IDLE;
                        r_d.done     = 1'b1;
                        r_d.no_limit = 1'b1;
                    end else begin
                        r_d.code = r_q.code + 1'b1;
                    end
                end
            end
            default: r_d.state = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= CAL_IDLE;
            r_q.code     <= '0;
            r_q.done     <= 1'b0;
            r_q.no_limit <= 1'b0;
            r_q.ok       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code     = r_q.code;
    assign busy     = (r_q.state == CAL_SEARCH);
    assign done     = r_q.done;
    assign no_limit = r_q.no_limit;
    assign cal_ok   = r_q.ok;

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_tick && !cmp_above && code != CODE_MAX) |=> (code == $past(code) + 1'b1));
    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_tick) |=> $stable(code));
    // R5
    nolim_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_limit |-> (code == CODE_MAX && !cal_ok));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_tick && cal_start) |=> busy);
endmodule

// File: rtl/ilim_trip_map.sv
module ilim_trip_map #(
    parameter int unsigned CODE_W       = 6,
    parameter int unsigned LOW_CODE_MAX = 10,
    parameter bit          DOUBLE_SAT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              cal_ok,
    input  logic              busy,
    input  logic              softstart,
    output logic [CODE_W:0]   trip_code,
    output logic              trip_enable
);
    localparam logic [CODE_W-1:0] LOW_LIM  = CODE_W'(LOW_CODE_MAX);
    localparam logic [CODE_W:0]   SAT_CODE = {1'b0, {CODE_W{1'b1}}};

    logic [CODE_W-1:0] base;
    logic [CODE_W:0]   doubled;
    logic [CODE_W:0]   scaled;

    assign trip_enable = cal_ok && !busy;
    assign base        = (code <= LOW_LIM) ? '0 : code;
    assign doubled     = {base, 1'b0};

    generate
        if (DOUBLE_SAT) begin : g_sat
            assign scaled = softstart ? ((doubled > SAT_CODE) ? SAT_CODE : doubled)
                                      : {1'b0, base};
        end else begin : g_wide
            assign scaled = softstart ? doubled : {1'b0, base};
        end
    endgenerate

    assign trip_code = trip_enable ? scaled : '0;

    // R9
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_enable |-> (trip_code == '0));
endmodule

// File: rtl/ilim_cal_top.sv
module ilim_cal_top #(
    parameter int unsigned CODE_W       = 6,
    parameter int unsigned SETTLE_CLKS  = 4,
    parameter int unsigned LOW_CODE_MAX = 10,
    parameter bit          DOUBLE_SAT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic              cmp_above,
    input  logic              softstart_active,
    output logic [CODE_W-1:0] dac_code,
    output logic              cal_busy,
    output logic              cal_done,
    output logic              no_limit,
    output logic              trip_enable,
    output logic [CODE_W:0]   trip_code
);
    logic step_tick;
    logic cal_ok;

    ilim_step_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cal_busy),
        .step_tick (step_tick)
    );

    ilim_search_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .cmp_above (cmp_above),
        .step_tick (step_tick),
        .code      (dac_code),
        .busy      (cal_busy),
        .done      (cal_done),
        .no_limit  (no_limit),
        .cal_ok    (cal_ok)
    );

    ilim_trip_map #(
        .CODE_W       (CODE_W),
        .LOW_CODE_MAX (LOW_CODE_MAX),
        .DOUBLE_SAT   (DOUBLE_SAT)
    ) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .code        (dac_code),
        .cal_ok      (cal_ok),
        .busy        (cal_busy),
        .softstart   (softstart_active),
        .trip_code   (trip_code),
        .trip_enable (trip_enable)
    );

    // R6
    low_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code <= CODE_W'(LOW_CODE_MAX)) |-> (trip_code == '0));
    // R7
    double_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (softstart_active && !DOUBLE_SAT) |-> !trip_code[0]);
    // R9
    busy_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !trip_enable);
endmodule

// File: tb/sim_ilim_cal_top.sv
module sim_ilim_cal_top;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic       softstart_active = 1'b0;
    logic       cmp_above;
    logic [5:0] dac_code;
    logic       cal_busy, cal_done, no_limit, trip_enable;
    logic [6:0] trip_code;
    logic [7:0] thr = 8'd200;

    always #10 clk = ~clk;

    assign cmp_above = ({2'b00, dac_code} >= thr);

    ilim_cal_top u0 (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_above(cmp_above),
        .softstart_active(softstart_active), .dac_code(dac_code), .cal_busy(cal_busy),
        .cal_done(cal_done), .no_limit(no_limit), .trip_enable(trip_enable),
        .trip_code(trip_code)
    );

    typedef struct {
        int code;
        int nolim;
        int lat;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int start_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: pop expected results as cal_done appears
    always @(negedge clk) begin
        if (rst_n && cal_done) begin
            if (q.size() == 0) begin
                chk("R4 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3 stored code", int'(dac_code), e.code);
                chk("R5 no_limit flag", int'(no_limit), e.nolim);
                chk("R4 done latency", cyc - start_cyc, e.lat);
            end
        end
    end

    // driver: launch a search and push its expected result
    task automatic run_cal(input int t, input bit probe, input bit restart);
        exp_t e;
        int c;
        thr = 8'(t);
        c = (t > 63) ? 63 : t;
        e.code  = c;
        e.nolim = (t > 63) ? 1 : 0;
        e.lat   = (c + 1) * S + 1;
        @(negedge clk);
        cal_start = 1'b1;
        start_cyc = cyc;
        q.push_back(e);
        @(negedge clk);
        cal_start = 1'b0;
        if (probe) begin
            chk("R2 first code", int'(dac_code), 0);
            chk("R9 enable low while busy", int'(trip_enable), 0);
            repeat (S - 1) @(negedge clk);
            chk("R2 code held within step", int'(dac_code), 0);
            @(negedge clk);
            chk("R2 second code", int'(dac_code), 1);
            repeat (S) @(negedge clk);
            chk("R2 third code", int'(dac_code), 2);
        end
        if (restart) begin
            repeat (S + 1) @(negedge clk);
            cal_start = 1'b1;
            @(negedge clk);
            cal_start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 busy", int'(cal_busy), 0);
        chk("R1 done", int'(cal_done), 0);
        chk("R1 no_limit", int'(no_limit), 0);
        chk("R1 trip_enable", int'(trip_enable), 0);
        chk("R1 trip_code", int'(trip_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cal(20, 1'b1, 1'b0);
        chk("R9 enable after crossing", int'(trip_enable), 1);
        chk("R6 pass-through", int'(trip_code), 20);
        softstart_active = 1'b1;
        #1;
        chk("R7 doubled", int'(trip_code), 40);
        softstart_active = 1'b0;
        #1;
        chk("R7 restored", int'(trip_code), 20);

        thr = 8'd0;
        repeat (5) @(negedge clk);
        chk("R3 idle cmp ignored", int'(dac_code), 20);

        run_cal(30, 1'b0, 1'b1);
        chk("R8 code after ignored start", int'(trip_code), 30);

        run_cal(5, 1'b0, 1'b0);
        chk("R6 low code zero", int'(trip_code), 0);
        softstart_active = 1'b1;
        #1;
        chk("R6 low code zero in soft-start", int'(trip_code), 0);
        softstart_active = 1'b0;

        run_cal(10, 1'b0, 1'b0);
        chk("R6 boundary 10", int'(trip_code), 0);
        run_cal(11, 1'b0, 1'b0);
        chk("R6 boundary 11", int'(trip_code), 11);

        run_cal(0, 1'b0, 1'b0);
        chk("R3 immediate crossing", int'(dac_code), 0);

        run_cal(63, 1'b0, 1'b0);
        chk("R6 top code", int'(trip_code), 63);
        softstart_active = 1'b1;
        #1;
        chk("R7 wide bus 126", int'(trip_code), 126);
        softstart_active = 1'b0;

        run_cal(100, 1'b0, 1'b0);
        chk("R5 enable off", int'(trip_enable), 0);
        chk("R5 trip_code zero", int'(trip_code), 0);
        chk("R5 code held at top", int'(dac_code), 63);

        run_cal(25, 1'b0, 1'b0);
        chk("R5 no_limit cleared", int'(no_limit), 0);
        chk("R9 enable restored", int'(trip_enable), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule